// File: doc/BRIEF.md
# Command Decoder and Interrupt Status Port

This block sits behind a single 16-bit host register offset of a network controller. A host write to that offset is decoded as a command: the upper five bits choose the operation and the lower eleven bits carry its argument. The same offset, when read, returns the controller's interrupt status. That status includes the latched event sources, an interrupt latch, a busy flag and the number of the register window that is currently selected.

Event pulses from the transmit, receive and statistics logic set the status source bits. The host clears them by writing an acknowledge command. The host also sets two masks. The interrupt-enable mask decides which sources may raise the interrupt output. The indication mask decides which sources show up in the status word. Datapath commands (enable, disable and reset of the receiver and transmitter) leave the block as one-cycle pulses. A receiver or transmitter reset also keeps the busy flag high for a fixed number of cycles.

The busy sequencer is a small state machine with three states. BZ_IDLE is the resting state. BZ_RX_RST is entered from BZ_IDLE on an accepted receiver reset, and BZ_TX_RST is entered from BZ_IDLE on an accepted transmitter reset. Each reset state returns to BZ_IDLE when its hold counter reaches zero.

Top module: `nic_cmd_status_port`

## Requirements
- R1: A command is a write with the opcode in bits 15:11 and the argument in bits 10:0. An opcode outside the set listed here (for example 2) changes no output and no status bit.
- R2: Opcode 1 loads the window number from argument bits 2:0. The window appears on `window_o` and in status bits 15:13 from the cycle after the write. The other argument bits are ignored.
- R3: Each event input sets one status bit in the cycle after its pulse: adapter failure sets bit 1, transmit complete bit 2, transmit room bit 3, receive complete bit 4, receive early bit 5 and statistics due bit 7. Opcode 12 sets bit 6. Any source that gets set also sets the latch, which is bit 0.
- R4: Opcode 13 clears every latched bit, latch included, whose position is set in argument bits 7:0. If an event arrives in the same cycle as an acknowledge that would clear its bit, the event wins and the bit stays set.
- R5: Opcode 14 loads the interrupt-enable mask and opcode 15 loads the indication mask, each from argument bits 7:1. Status bits 7:1 show a source only when its indication bit is set. Bit 0 always shows the latch.
- R6: `irq_o` is high exactly while the latch is set and at least one source bit is set whose interrupt-enable bit is also set.
- R7: Opcode 16 loads the receive filter from argument bits 3:0. In the filter, bit 0 accepts frames for the station address, bit 1 accepts multicast, bit 2 accepts broadcast and bit 3 accepts all frames.
- R8: Opcodes 3, 4, 9 and 10 each produce a single one-cycle pulse in the cycle after the write. Opcode 3 pulses `rx_disable_o`, opcode 4 pulses `rx_enable_o`, opcode 9 pulses `tx_enable_o` and opcode 10 pulses `tx_disable_o`.
- R9: When idle, opcode 5 (receiver reset) or opcode 11 (transmitter reset) produces a one-cycle pulse on `rx_reset_o` or `tx_reset_o`. It also raises `busy_o` and status bit 12 for exactly RST_CYCLES cycles, starting the cycle after the write.
- R10: A reset command written while busy is ignored. It produces no pulse and does not lengthen the busy period.
- R11: After reset, every output is zero: status, irq, busy, window, filter and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command offset |
| cmd_wdata | input | 16 | Command word: opcode 15:11, argument 10:0 |
| ev_fail | input | 1 | Adapter failure event pulse |
| ev_tx_done | input | 1 | Transmit complete event pulse |
| ev_tx_room | input | 1 | Transmit space available event pulse |
| ev_rx_done | input | 1 | Receive complete event pulse |
| ev_rx_early | input | 1 | Receive early event pulse |
| ev_stats | input | 1 | Statistics update due event pulse |
| status_o | output | 16 | Status word read at the command offset |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Reset in progress |
| window_o | output | 3 | Selected register window |
| rx_filter_o | output | 4 | Receive filter setting |
| rx_disable_o | output | 1 | Receiver disable pulse |
| rx_enable_o | output | 1 | Receiver enable pulse |
| rx_reset_o | output | 1 | Receiver reset pulse |
| tx_enable_o | output | 1 | Transmitter enable pulse |
| tx_disable_o | output | 1 | Transmitter disable pulse |
| tx_reset_o | output | 1 | Transmitter reset pulse |

## Verification
The assertions assume that each write and each event input is a single-cycle pulse sampled at a rising edge. They also assume that `cmd_wdata` means nothing while `cmd_wr` is low. The bench drives every input on the falling edge and drops it right after the next rising edge, so each stimulus lasts exactly one cycle. It applies an acknowledge together with an event only where the tie is meant to be tested. It issues a second reset only while the first one is still holding busy, which is how the hold-counter assertion sees a busy run that the ignored command must not stretch.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

    localparam int OP_W   = 5;
    localparam int ARG_W  = 11;
    localparam int WORD_W = OP_W + ARG_W;
    localparam int WIN_W  = 3;
    localparam int FILT_W = 4;
    localparam int SRC_HI = 7;
    localparam int BUSY_BIT = 12;

    typedef enum logic [OP_W-1:0] {
        OP_WINDOW  = 5'd1,
        OP_RX_DIS  = 5'd3,
        OP_RX_EN   = 5'd4,
        OP_RX_RST  = 5'd5,
        OP_TX_EN   = 5'd9,
        OP_TX_DIS  = 5'd10,
        OP_TX_RST  = 5'd11,
        OP_REQ_IRQ = 5'd12,
        OP_ACK     = 5'd13,
        OP_INT_EN  = 5'd14,
        OP_IND_EN  = 5'd15,
        OP_FILTER  = 5'd16
    } cmd_op_e;

    typedef enum logic [1:0] {
        BZ_IDLE,
        BZ_RX_RST,
        BZ_TX_RST
    } busy_state_e;

    typedef struct packed {
        logic sel_win;
        logic rx_dis;
        logic rx_en;
        logic rx_rst;
        logic tx_en;
        logic tx_dis;
        logic tx_rst;
        logic req_irq;
        logic ack;
        logic int_ld;
        logic ind_ld;
        logic filt_ld;
    } cmd_strb_t;

endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
    import nic_cmd_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output cmd_strb_t         strb,
    output logic [7:0]        arg_lo
);

    logic [OP_W-1:0] op;
    logic            arg_hi_unused;

    assign op            = wdata[WORD_W-1:ARG_W];
    assign arg_lo        = wdata[7:0];
    assign arg_hi_unused = ^wdata[ARG_W-1:8];

    always_comb begin
        strb = '0;
        if (wr_en) begin
            case (op)
                OP_WINDOW:  strb.sel_win = 1'b1;
                OP_RX_DIS:  strb.rx_dis  = 1'b1;
                OP_RX_EN:   strb.rx_en   = 1'b1;
                OP_RX_RST:  strb.rx_rst  = 1'b1;
                OP_TX_EN:   strb.tx_en   = 1'b1;
                OP_TX_DIS:  strb.tx_dis  = 1'b1;
                OP_TX_RST:  strb.tx_rst  = 1'b1;
                OP_REQ_IRQ: strb.req_irq = 1'b1;
                OP_ACK:     strb.ack     = 1'b1;
                OP_INT_EN:  strb.int_ld  = 1'b1;
                OP_IND_EN:  strb.ind_ld  = 1'b1;
                OP_FILTER:  strb.filt_ld = 1'b1;
                default:    strb         = '0;
            endcase
        end
    end

endmodule

// File: rtl/nic_irq_latch.sv
module nic_irq_latch
    import nic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_HI:1]   ev_set,
    input  logic              ack,
    input  logic [SRC_HI:0]   ack_mask,
    input  logic              int_ld,
    input  logic              ind_ld,
    input  logic [SRC_HI:1]   mask_val,
    output logic              latch_o,
    output logic [SRC_HI:1]   view_o,
    output logic              irq_o
);

    logic [SRC_HI:1] src_q, src_d;
    logic [SRC_HI:1] int_en_q, ind_en_q;
    logic            latch_q, latch_d;

    for (genvar k = 1; k <= SRC_HI; k++) begin : g_src
        assign src_d[k] = ev_set[k]                ? 1'b1 :
                          (ack && ack_mask[k])     ? 1'b0 : src_q[k];
    end

    assign latch_d = (|ev_set)                 ? 1'b1 :
                     (ack && ack_mask[0])      ? 1'b0 : latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            latch_q  <= 1'b0;
            int_en_q <= '0;
            ind_en_q <= '0;
        end else begin
            src_q   <= src_d;
            latch_q <= latch_d;
            if (int_ld) int_en_q <= mask_val;
            if (ind_ld) ind_en_q <= mask_val;
        end
    end

    assign latch_o = latch_q;
    assign view_o  = src_q & ind_en_q;
    assign irq_o   = latch_q & (|(src_q & int_en_q));

    for (genvar k = 1; k <= SRC_HI; k++) begin : g_chk
        AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[k] |=> (src_q[k] && latch_q)); // R3
        AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && ack_mask[k] && !ev_set[k]) |=> !src_q[k]); // R4
    end

    AST_IRQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_mask[0] && !(|ev_set)) |=> !irq_o); // R6

endmodule

// File: rtl/nic_busy_fsm.sv
module nic_busy_fsm
    import nic_cmd_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_rst_req,
    input  logic tx_rst_req,
    output logic rx_rst_go,
    output logic tx_rst_go,
    output logic busy_o
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    busy_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BZ_IDLE: begin
                if (rx_rst_req)      state_d = BZ_RX_RST;
                else if (tx_rst_req) state_d = BZ_TX_RST;
            end
            BZ_RX_RST: if (cnt_q == '0) state_d = BZ_IDLE;
            BZ_TX_RST: if (cnt_q == '0) state_d = BZ_IDLE;
            default:   state_d = BZ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BZ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BZ_IDLE) cnt_q <= CNT_LOAD;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy_o    = 1'b0;
        rx_rst_go = 1'b0;
        tx_rst_go = 1'b0;
        unique case (state_q)
            BZ_IDLE: begin
                rx_rst_go = rx_rst_req;
                tx_rst_go = tx_rst_req && !rx_rst_req;
            end
            BZ_RX_RST: busy_o = 1'b1;
            BZ_TX_RST: busy_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    logic [CNT_W:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    AST_BUSY_AFTER_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst_go || tx_rst_go) |=> busy_o); // R9
    AST_BUSY_SPAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CNT_W+1)'(RST_CYCLES)); // R10
    AST_RESET_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != '0) |=> $stable(state_q)); // R10

endmodule

// File: rtl/nic_cmd_status_port.sv
module nic_cmd_status_port
    import nic_cmd_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_wdata,
    input  logic        ev_fail,
    input  logic        ev_tx_done,
    input  logic        ev_tx_room,
    input  logic        ev_rx_done,
    input  logic        ev_rx_early,
    input  logic        ev_stats,
    output logic [15:0] status_o,
    output logic        irq_o,
    output logic        busy_o,
    output logic [2:0]  window_o,
    output logic [3:0]  rx_filter_o,
    output logic        rx_disable_o,
    output logic        rx_enable_o,
    output logic        rx_reset_o,
    output logic        tx_enable_o,
    output logic        tx_disable_o,
    output logic        tx_reset_o
);

    cmd_strb_t        strb;
    logic [7:0]       arg_lo;
    logic [SRC_HI:1]  ev_set;
    logic [SRC_HI:1]  view;
    logic             latch;
    logic             rx_go, tx_go, busy;
    logic [WIN_W-1:0] win_q;
    logic [FILT_W-1:0] filt_q;
    logic [5:0]       pulse_q;

    nic_cmd_decode i_decode (
        .wr_en  (cmd_wr),
        .wdata  (cmd_wdata),
        .strb   (strb),
        .arg_lo (arg_lo)
    );

    assign ev_set = {ev_stats, strb.req_irq, ev_rx_early, ev_rx_done,
                     ev_tx_room, ev_tx_done, ev_fail};

    nic_irq_latch i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_set   (ev_set),
        .ack      (strb.ack),
        .ack_mask (arg_lo),
        .int_ld   (strb.int_ld),
        .ind_ld   (strb.ind_ld),
        .mask_val (arg_lo[SRC_HI:1]),
        .latch_o  (latch),
        .view_o   (view),
        .irq_o    (irq_o)
    );

    nic_busy_fsm #(.RST_CYCLES(RST_CYCLES)) i_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_rst_req (strb.rx_rst),
        .tx_rst_req (strb.tx_rst),
        .rx_rst_go  (rx_go),
        .tx_rst_go  (tx_go),
        .busy_o     (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            filt_q  <= '0;
            pulse_q <= '0;
        end else begin
            if (strb.sel_win) win_q  <= arg_lo[WIN_W-1:0];
            if (strb.filt_ld) filt_q <= arg_lo[FILT_W-1:0];
            pulse_q <= {tx_go, strb.tx_dis, strb.tx_en,
                        rx_go, strb.rx_en, strb.rx_dis};
        end
    end

    always_comb begin
        status_o                    = '0;
        status_o[0]                 = latch;
        status_o[SRC_HI:1]          = view;
        status_o[BUSY_BIT]          = busy;
        status_o[15:15-WIN_W+1]     = win_q;
    end

    assign busy_o       = busy;
    assign window_o     = win_q;
    assign rx_filter_o  = filt_q;
    assign rx_disable_o = pulse_q[0];
    assign rx_enable_o  = pulse_q[1];
    assign rx_reset_o   = pulse_q[2];
    assign tx_enable_o  = pulse_q[3];
    assign tx_disable_o = pulse_q[4];
    assign tx_reset_o   = pulse_q[5];

    AST_WINDOW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        strb.sel_win |=> (window_o == $past(cmd_wdata[2:0]))); // R2
    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.filt_ld |=> $stable(rx_filter_o)); // R7
    AST_RESET_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_reset_o || tx_reset_o) |=> !(rx_reset_o || tx_reset_o)); // R9
    AST_PULSES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_q)); // R8

endmodule

// File: tb/test_nic_cmd_status_port.sv
module test_nic_cmd_status_port;

    localparam int CLK_PERIOD = 10;
    localparam int RSTC       = 5;
    localparam int NVEC       = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr;
    logic [15:0] cmd_wdata;
    logic [5:0]  ev;
    logic [15:0] status_o;
    logic        irq_o, busy_o;
    logic [2:0]  window_o;
    logic [3:0]  rx_filter_o;
    logic        rx_disable_o, rx_enable_o, rx_reset_o;
    logic        tx_enable_o, tx_disable_o, tx_reset_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_cmd_status_port #(.RST_CYCLES(RSTC)) i_nic_cmd_status_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_wdata    (cmd_wdata),
        .ev_fail      (ev[0]),
        .ev_tx_done   (ev[1]),
        .ev_tx_room   (ev[2]),
        .ev_rx_done   (ev[3]),
        .ev_rx_early  (ev[4]),
        .ev_stats     (ev[5]),
        .status_o     (status_o),
        .irq_o        (irq_o),
        .busy_o       (busy_o),
        .window_o     (window_o),
        .rx_filter_o  (rx_filter_o),
        .rx_disable_o (rx_disable_o),
        .rx_enable_o  (rx_enable_o),
        .rx_reset_o   (rx_reset_o),
        .tx_enable_o  (tx_enable_o),
        .tx_disable_o (tx_disable_o),
        .tx_reset_o   (tx_reset_o)
    );

    // {wr, wdata, ev[5:0], expected status, expected irq}
    localparam logic [39:0] VECS [NVEC] = '{
        {1'b1, 16'h78FE, 6'h00, 16'h0000, 1'b0}, // R5 indication all
        {1'b1, 16'h7014, 6'h00, 16'h0000, 1'b0}, // R5 enable bits 2,4
        {1'b0, 16'h0000, 6'h01, 16'h0003, 1'b0}, // R3 failure, not enabled
        {1'b0, 16'h0000, 6'h02, 16'h0007, 1'b1}, // R3 R6 tx done
        {1'b1, 16'h6804, 6'h00, 16'h0003, 1'b0}, // R4 ack bit 2
        {1'b0, 16'h0000, 6'h08, 16'h0013, 1'b1}, // R3 rx done
        {1'b1, 16'h6801, 6'h00, 16'h0012, 1'b0}, // R4 R6 ack latch
        {1'b1, 16'h6000, 6'h00, 16'h0053, 1'b1}, // R3 request irq
        {1'b1, 16'h0805, 6'h00, 16'hA053, 1'b1}, // R2 window 5
        {1'b1, 16'h68FF, 6'h20, 16'hA081, 1'b0}, // R4 event wins over ack
        {1'b1, 16'h7800, 6'h00, 16'hA001, 1'b0}, // R5 indication off
        {1'b1, 16'h7080, 6'h00, 16'hA001, 1'b1}, // R6 enable bit 7
        {1'b1, 16'h17FF, 6'h00, 16'hA001, 1'b1}, // R1 unused opcode
        {1'b1, 16'h0FFA, 6'h00, 16'h4001, 1'b1}  // R1 R2 high arg bits dropped
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(input logic wr, input logic [15:0] wd, input logic [5:0] e);
        cmd_wr    = wr;
        cmd_wdata = wd;
        ev        = e;
        @(posedge clk);
        #1;
        cmd_wr    = 1'b0;
        cmd_wdata = '0;
        ev        = '0;
        @(negedge clk);
    endtask

    function automatic logic [5:0] pulses();
        return {tx_reset_o, tx_disable_o, tx_enable_o, rx_reset_o, rx_enable_o, rx_disable_o};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; ev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 status", status_o, 16'h0000);
        chk("R11 irq/busy", {14'd0, irq_o, busy_o}, 16'h0000);
        chk("R11 window/filter", {9'd0, window_o, rx_filter_o}, 16'h0000);
        chk("R11 pulses", {10'd0, pulses()}, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            cyc(VECS[i][39], VECS[i][38:23], VECS[i][22:17]);
            chk($sformatf("R3/R4/R5 vec%0d status", i), status_o, VECS[i][16:1]);
            chk($sformatf("R6 vec%0d irq", i), {15'd0, irq_o}, {15'd0, VECS[i][0]});
        end
        chk("R2 window port", {13'd0, window_o}, 16'd2);

        // R7 filter
        cyc(1'b1, 16'h800D, 6'h00);
        chk("R7 filter", {12'd0, rx_filter_o}, 16'h000D);
        cyc(1'b1, 16'h801F, 6'h00);
        chk("R7 filter width", {12'd0, rx_filter_o}, 16'h000F);

        // R8 datapath pulses
        cyc(1'b1, 16'h1800, 6'h00);
        chk("R8 rx disable", {10'd0, pulses()}, 16'h0001);
        cyc(1'b0, 16'h0000, 6'h00);
        chk("R8 pulse ends", {10'd0, pulses()}, 16'h0000);
        cyc(1'b1, 16'h2000, 6'h00);
        chk("R8 rx enable", {10'd0, pulses()}, 16'h0002);
        cyc(1'b1, 16'h4800, 6'h00);
        chk("R8 tx enable", {10'd0, pulses()}, 16'h0008);
        cyc(1'b1, 16'h5000, 6'h00);
        chk("R8 tx disable", {10'd0, pulses()}, 16'h0010);
        cyc(1'b0, 16'h0000, 6'h00);
        chk("R8 idle", {10'd0, pulses()}, 16'h0000);

        // R9 receiver reset, R10 transmit reset while busy
        cyc(1'b1, 16'h2800, 6'h00);
        chk("R9 rx reset pulse", {10'd0, pulses()}, 16'h0004);
        chk("R9 busy status", {15'd0, status_o[12]}, 16'h0001);
        n = 1;
        cyc(1'b1, 16'h5800, 6'h00);
        chk("R10 no pulse while busy", {10'd0, pulses()}, 16'h0000);
        if (busy_o) n++;
        for (int k = 0; k < 40 && busy_o; k++) begin
            cyc(1'b0, 16'h0000, 6'h00);
            if (busy_o) n++;
        end
        chk("R10 busy length", 16'(n), 16'(RSTC));
        chk("R9 busy cleared", {15'd0, status_o[12]}, 16'h0000);

        cyc(1'b1, 16'h5800, 6'h00);
        chk("R9 tx reset pulse", {10'd0, pulses()}, 16'h0020);
        n = busy_o ? 1 : 0;
        for (int k = 0; k < 40 && busy_o; k++) begin
            cyc(1'b0, 16'h0000, 6'h00);
            if (busy_o) n++;
        end
        chk("R9 tx busy length", 16'(n), 16'(RSTC));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule